// File: doc/BRIEF.md
# Channel-Parallel Accumulate and Requantize Unit

This block closes out one output kernel of a convolution datapath. Each cycle it may receive a beat of per-channel signed products, one product for each input channel of the current slice. It adds these products in a registered pairwise tree, so the tree takes one level per halving. The running total is then carried in an accumulator across as many beats as the kernel needs, which covers every channel slice and every kernel-window tap.

A beat flagged as final carries the kernel's bias, scale multiplier and shift amount along the tree with it. When that beat reaches the accumulator, the total is summed with the bias. The result is multiplied by the unsigned scale, rounded to nearest, shifted right arithmetically, and saturated to a signed 8-bit value. A new kernel can follow on the very next cycle, because the accumulator restarts by itself on the first beat after a final beat.

Top module: `chan_acc_requant`

## Requirements
- R1: With the default of 32 channels, a single final beat yields clamp(((sum + bias) * scale + offset) >>> shift), where sum is the signed sum of all 32 products on that beat. Products are packed with channel n in bits [n*PROD_W +: PROD_W].
- R2: The result appears on the eighth rising edge, counting the edge that samples the final beat: five tree levels and three requantize stages. The output valid is high for exactly one cycle per final beat.
- R3: Beats of one kernel accumulate into a 32-bit two's-complement total, and idle cycles may fall between them.
- R4: The first beat after a final beat starts a fresh total. Kernels may follow each other with no idle cycle, and nothing carries over between them.
- R5: Bias (32-bit signed), scale (16-bit unsigned) and shift (5-bit, 0 to 31) are taken only from the final beat. Their values on other beats have no effect.
- R6: The rounding offset is 2^(shift-1) for a nonzero shift and 0 for shift 0, so halves round toward positive infinity.
- R7: Requantized values above 127 give 127, and values below -128 give -128.
- R8: After reset the output valid is low. Products and flags presented while the input valid is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat present on the product inputs |
| inLast | input | 1 | Beat is the final one of the kernel |
| inProducts | input | NUM_CH*PROD_W | Packed signed per-channel products |
| inBias | input | BIAS_W | Signed kernel bias, used with the final beat |
| inScale | input | SCALE_W | Unsigned requantize multiplier, used with the final beat |
| inShift | input | SHIFT_W | Right-shift amount, used with the final beat |
| outValid | output | 1 | Result strobe |
| outData | output | OUT_W | Signed requantized result |

## Verification
The bench uses the default build: 32 channels, 17-bit products, a 16-bit scale and a 5-bit shift. With these values, full-scale products combined with a large scale push the result past both clamp limits. Small single-channel values show rounding ties at a shift of 4. Sending single-beat kernels back to back shows whether any state leaks from one kernel into the next.

// File: rtl/chan_acc_pkg.sv
package chan_acc_pkg;
  typedef struct packed {
    logic accLoad;  // start a fresh total with the tree sum
    logic accAdd;   // add the tree sum to the running total
    logic finish;   // final beat: launch bias add and requantize
  } accStrobe_t;
endpackage

// File: rtl/chan_acc_tree.sv
module chan_acc_tree #(
  parameter int NUM_CH  = 32,
  parameter int PROD_W  = 17,
  parameter int BIAS_W  = 32,
  parameter int SCALE_W = 16,
  parameter int SHIFT_W = 5,
  localparam int LEVELS = $clog2(NUM_CH),
  localparam int SUM_W  = PROD_W + LEVELS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inLast,
  input  logic [NUM_CH*PROD_W-1:0] inProducts,
  input  logic [BIAS_W-1:0]        inBias,
  input  logic [SCALE_W-1:0]       inScale,
  input  logic [SHIFT_W-1:0]       inShift,
  output logic                     treeValid,
  output logic                     treeLast,
  output logic signed [SUM_W-1:0]  treeSum,
  output logic [BIAS_W-1:0]        treeBias,
  output logic [SCALE_W-1:0]       treeScale,
  output logic [SHIFT_W-1:0]       treeShift
);
  for (genvar l = 0; l < LEVELS; l++) begin : gLvl
    localparam int CNT = NUM_CH >> (l + 1);
    for (genvar n = 0; n < CNT; n++) begin : gNode
      logic signed [SUM_W-1:0] opA, opB, sumQ;
      if (l == 0) begin : gIn
        assign opA = SUM_W'($signed(inProducts[(2*n)*PROD_W +: PROD_W]));
        assign opB = SUM_W'($signed(inProducts[(2*n+1)*PROD_W +: PROD_W]));
      end else begin : gMid
        assign opA = gLvl[l-1].gNode[2*n].sumQ;
        assign opB = gLvl[l-1].gNode[2*n+1].sumQ;
      end
      always_ff @(posedge clk) sumQ <= opA + opB;
    end
  end

  logic               vldQ   [LEVELS];
  logic               lastQ  [LEVELS];
  logic [BIAS_W-1:0]  biasQ  [LEVELS];
  logic [SCALE_W-1:0] scaleQ [LEVELS];
  logic [SHIFT_W-1:0] shiftQ [LEVELS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < LEVELS; k++) begin
        vldQ[k]  <= 1'b0;
        lastQ[k] <= 1'b0;
      end
    end else begin
      vldQ[0]  <= inValid;
      lastQ[0] <= inValid & inLast;
      for (int k = 1; k < LEVELS; k++) begin
        vldQ[k]  <= vldQ[k-1];
        lastQ[k] <= lastQ[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    biasQ[0]  <= inBias;
    scaleQ[0] <= inScale;
    shiftQ[0] <= inShift;
    for (int k = 1; k < LEVELS; k++) begin
      biasQ[k]  <= biasQ[k-1];
      scaleQ[k] <= scaleQ[k-1];
      shiftQ[k] <= shiftQ[k-1];
    end
  end

  assign treeValid = vldQ[LEVELS-1];
  assign treeLast  = lastQ[LEVELS-1];
  assign treeSum   = gLvl[LEVELS-1].gNode[0].sumQ;
  assign treeBias  = biasQ[LEVELS-1];
  assign treeScale = scaleQ[LEVELS-1];
  assign treeShift = shiftQ[LEVELS-1];

  AST_TREE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    treeValid |-> $past(inValid, LEVELS)); // R2
endmodule

// File: rtl/chan_acc_ctrl.sv
module chan_acc_ctrl
  import chan_acc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       treeValid,
  input  logic       treeLast,
  output accStrobe_t strobe
);
  logic freshQ;

  always_ff @(posedge clk) begin
    if (!rstN)          freshQ <= 1'b1;
    else if (treeValid) freshQ <= treeLast;
  end

  always_comb begin
    strobe.accLoad = treeValid & freshQ;
    strobe.accAdd  = treeValid & ~freshQ;
    strobe.finish  = treeValid & treeLast;
  end

  AST_RESTART_AFTER_FIN: assert property (@(posedge clk) disable iff (!rstN)
    (treeValid && $past(strobe.finish)) |-> strobe.accLoad); // R4
endmodule

// File: rtl/chan_acc_datapath.sv
module chan_acc_datapath
  import chan_acc_pkg::*;
#(
  parameter int SUM_W   = 22,
  parameter int ACC_W   = 32,
  parameter int BIAS_W  = 32,
  parameter int SCALE_W = 16,
  parameter int SHIFT_W = 5,
  parameter int OUT_W   = 8,
  localparam int BSUM_W = ((ACC_W > BIAS_W) ? ACC_W : BIAS_W) + 1,
  localparam int MUL_W  = BSUM_W + SCALE_W + 1,
  localparam int RND_W  = MUL_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  accStrobe_t              strobe,
  input  logic signed [SUM_W-1:0] treeSum,
  input  logic [BIAS_W-1:0]       treeBias,
  input  logic [SCALE_W-1:0]      treeScale,
  input  logic [SHIFT_W-1:0]      treeShift,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);
  localparam logic signed [RND_W-1:0] MAX_OUT = RND_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] MIN_OUT = -RND_W'(2 ** (OUT_W - 1));

  logic signed [ACC_W-1:0]  accQ, sumExt, accNext;
  logic signed [BSUM_W-1:0] biasedQ;
  logic [SCALE_W-1:0]       scaleA;
  logic [SHIFT_W-1:0]       shiftA, shiftB;
  logic                     validA, validB;
  logic signed [MUL_W-1:0]  prodQ;
  logic signed [RND_W-1:0]  roundOff, rounded;

  assign sumExt  = ACC_W'(treeSum);
  assign accNext = strobe.accLoad ? sumExt : accQ + sumExt;

  // Stage A: accumulate, and on the final beat fold in the bias
  always_ff @(posedge clk) begin
    if (strobe.accLoad || strobe.accAdd) accQ <= accNext;
    biasedQ <= BSUM_W'(accNext) + BSUM_W'($signed(treeBias));
    scaleA  <= treeScale;
    shiftA  <= treeShift;
  end

  // Stage B: scale multiply
  always_ff @(posedge clk) begin
    prodQ  <= MUL_W'(biasedQ) * MUL_W'($signed({1'b0, scaleA}));
    shiftB <= shiftA;
  end

  // Stage C: round, shift, saturate
  assign roundOff = (shiftB == '0) ? '0 : (RND_W'(1) <<< (shiftB - 1'b1));
  assign rounded  = (RND_W'(prodQ) + roundOff) >>> shiftB;

  always_ff @(posedge clk) begin
    if      (rounded > MAX_OUT) outData <= MAX_OUT[OUT_W-1:0];
    else if (rounded < MIN_OUT) outData <= MIN_OUT[OUT_W-1:0];
    else                        outData <= rounded[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validA   <= 1'b0;
      validB   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      validA   <= strobe.finish;
      validB   <= validA;
      outValid <= validB;
    end
  end

  AST_OUT_FOLLOWS_FIN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.finish, 3)); // R2
  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accLoad || strobe.accAdd) |=> $stable(accQ)); // R8
endmodule

// File: rtl/chan_acc_requant.sv
module chan_acc_requant
  import chan_acc_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int PROD_W  = 17,
  parameter int ACC_W   = 32,
  parameter int BIAS_W  = 32,
  parameter int SCALE_W = 16,
  parameter int SHIFT_W = 5,
  parameter int OUT_W   = 8,
  localparam int SUM_W  = PROD_W + $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inLast,
  input  logic [NUM_CH*PROD_W-1:0] inProducts,
  input  logic [BIAS_W-1:0]        inBias,
  input  logic [SCALE_W-1:0]       inScale,
  input  logic [SHIFT_W-1:0]       inShift,
  output logic                     outValid,
  output logic [OUT_W-1:0]         outData
);
  logic                    treeValid, treeLast;
  logic signed [SUM_W-1:0] treeSum;
  logic [BIAS_W-1:0]       treeBias;
  logic [SCALE_W-1:0]      treeScale;
  logic [SHIFT_W-1:0]      treeShift;
  accStrobe_t              strobe;
  logic signed [OUT_W-1:0] dataS;

  chan_acc_tree #(.NUM_CH(NUM_CH), .PROD_W(PROD_W), .BIAS_W(BIAS_W),
                  .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W)) tree_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inProducts(inProducts), .inBias(inBias), .inScale(inScale), .inShift(inShift),
    .treeValid(treeValid), .treeLast(treeLast), .treeSum(treeSum),
    .treeBias(treeBias), .treeScale(treeScale), .treeShift(treeShift));

  chan_acc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .treeValid(treeValid), .treeLast(treeLast),
    .strobe(strobe));

  chan_acc_datapath #(.SUM_W(SUM_W), .ACC_W(ACC_W), .BIAS_W(BIAS_W),
                      .SCALE_W(SCALE_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .treeSum(treeSum),
    .treeBias(treeBias), .treeScale(treeScale), .treeShift(treeShift),
    .outValid(outValid), .outData(dataS));

  assign outData = dataS;
endmodule

// File: tb/chan_acc_requant_tb_top.sv
module chan_acc_requant_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 32;
  localparam int PROD_W = 17;
  localparam int LAT    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [NUM_CH*PROD_W-1:0] inProducts = '0;
  logic [31:0] inBias = '0;
  logic [15:0] inScale = '0;
  logic [4:0]  inShift = '0;
  logic        outValid;
  logic [7:0]  outData;

  int checks = 0, errors = 0;
  int prodVals [NUM_CH];
  longint kernSum;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_acc_requant dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inProducts(inProducts), .inBias(inBias), .inScale(inScale),
    .inShift(inShift), .outValid(outValid), .outData(outData));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect8(longint acc, longint bias, longint scale, int sh);
    longint b, r;
    b = longint'(int'(acc)) + bias;
    r = b * scale + ((sh == 0) ? 64'sd0 : (64'sd1 <<< (sh - 1)));
    r = r >>> sh;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  function automatic longint packVals();
    longint s = 0;
    for (int n = 0; n < NUM_CH; n++) begin
      inProducts[n*PROD_W +: PROD_W] = PROD_W'(prodVals[n]);
      s += prodVals[n];
    end
    return s;
  endfunction

  task automatic setConst(int v);
    for (int n = 0; n < NUM_CH; n++) prodVals[n] = v;
  endtask

  task automatic driveBeat(logic last, int bias, int scale, int sh);
    @(negedge clk);
    kernSum += packVals();
    inValid = 1'b1;
    inLast  = last;
    inBias  = bias;
    inScale = 16'(scale);
    inShift = 5'(sh);
  endtask

  task automatic waitOut(output int lat, output longint val);
    lat = 0;
    do begin
      @(negedge clk);
      inValid = 1'b0;
      inLast  = 1'b0;
      lat++;
    end while (!outValid && lat < 30);
    val = longint'($signed(outData));
  endtask

  task automatic runSingle(string req, int bias, int scale, int sh);
    int lat; longint v, e;
    kernSum = 0;
    driveBeat(1'b1, bias, scale, sh);
    e = expect8(kernSum, bias, scale, sh);
    waitOut(lat, v);
    check(req, v, e);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R8 reset valid", outValid, 0);
  endtask

  task automatic testSingle();
    int lat; longint v;
    for (int n = 0; n < NUM_CH; n++) prodVals[n] = n - 16;
    kernSum = 0;
    driveBeat(1'b1, 100, 1, 0);
    waitOut(lat, v);
    check("R1 single beat", v, expect8(kernSum, 100, 1, 0));
    check("R2 latency", lat, LAT);
    @(negedge clk);
    check("R2 one-cycle strobe", outValid, 0);
  endtask

  task automatic testMulti();
    int lat; longint v;
    kernSum = 0;
    for (int n = 0; n < NUM_CH; n++) prodVals[n] = n + 1;
    driveBeat(1'b0, 9999, 0, 31);          // R5: ignored side values
    @(negedge clk);                         // R8: junk while valid low
    inValid = 1'b0; inLast = 1'b1;
    setConst(5000); void'(packVals());
    @(negedge clk);
    setConst(3);
    driveBeat(1'b0, -7777, 65535, 1);
    setConst(-2);
    driveBeat(1'b1, -60, 1, 3);
    waitOut(lat, v);
    check("R3 R5 R8 multi-beat", v, expect8(kernSum, -60, 1, 3));
    check("R3 latency after last", lat, LAT);
  endtask

  task automatic testBackToBack();
    int lat; longint v;
    setConst(1);  kernSum = 0; driveBeat(1'b1, 10, 1, 0);
    setConst(-1); kernSum = 0; driveBeat(1'b1, 0, 1, 0);
    waitOut(lat, v);
    check("R4 first kernel", v, 42);
    @(negedge clk);
    check("R4 second valid", outValid, 1);
    check("R4 second kernel fresh", longint'($signed(outData)), -32);
  endtask

  task automatic testRound();
    setConst(0); prodVals[0] = 24;  runSingle("R6 round up 1.5", 0, 1, 4);
    setConst(0); prodVals[0] = -24; runSingle("R6 round -1.5", 0, 1, 4);
    setConst(0); prodVals[0] = 8;   runSingle("R6 tie 0.5", 0, 1, 4);
    setConst(0); prodVals[0] = 5;   runSingle("R6 shift zero", 0, 3, 0);
    setConst(0); prodVals[0] = 7;   runSingle("R6 shift 31", 0, 65535, 31);
  endtask

  task automatic testClamp();
    longint v; int lat;
    setConst(65535);  runSingle("R7 clamp high", 0, 1000, 0);
    setConst(-65536); runSingle("R7 clamp low", 0, 1000, 0);
    setConst(0); kernSum = 0;
    driveBeat(1'b1, 32'h7fffffff, 65535, 0);
    waitOut(lat, v);
    check("R7 bias extreme", v, 127);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testMulti();
    testBackToBack();
    testRound();
    testClamp();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule